// File: doc/BRIEF.md
# Program Counter Sequencer with Carry-Saving Return Stack

This block produces the fetch address of a small 4-bit processor. It holds a 12-bit program counter whose top bit selects a page and whose lower eleven bits count. Beside it sits an eight-level hardware return stack. Each level stores the carry flag together with a full return address. Subroutine calls and interrupt entries share those levels. When the stack is already full, a further push silently drops the oldest level.

Decode logic outside the block raises one or more operation strobes. The block samples them once per instruction cycle, which is four oscillator clocks long. At that edge it updates the counter, the stack and three small outputs: the carry value, the table-branch nibble and the accumulator nibble. The two return kinds differ as follows:
- The interrupt return restores the saved carry.
- The constant return keeps the live carry. It also loads the table-branch and accumulator nibbles from the low byte of the ROM word.

A table jump builds its target from three parts: the current page and high nibble, the table-branch nibble and the accumulator nibble.

Top module: `pcs_top`

## Requirements
- R1: After reset, `fetch_addr`, `carry_out`, `tbr_out` and `acc_out` are all zero and `cyc_strobe` is low. All eight stack levels hold zero.
- R2: `cyc_strobe` is high on one clock in every four. The first such clock is the third rising edge after reset is released, so updates begin at the fourth edge. Operation strobes are acted on only at a rising edge where `cyc_strobe` is high. At every other edge they have no effect on any output.
- R3: Increment adds one to `fetch_addr[10:0]`, wrapping from 0x7FF to 0x000. `fetch_addr[11]` is left unchanged.
- R4: Jump loads all twelve bits from `jump_addr`. Call loads bits 10:0 from `jump_addr` and keeps bit 11. Call pushes `{carry_in, incremented address}`, where the incremented address follows the rule in R3.
- R5: Interrupt entry pushes `{carry_in, fetch_addr}`, keeping the current address unchanged. It then loads the vector parameter, which defaults to 0x008.
- R6: Interrupt return pops the top level. It loads `fetch_addr` from bits 11:0 of that level and `carry_out` from bit 12.
- R7: Constant return pops the top level into `fetch_addr`, and `carry_out` takes `carry_in`. `tbr_out` takes `rom_data[7:4]` and `acc_out` takes `rom_data[3:0]`.
- R8: Table jump sets `fetch_addr` to `{fetch_addr[11:8], tbr_in, acc_in}`.
- R9: A push while eight levels are held discards the oldest level without any indication. The eight most recent levels remain and are popped newest first.
- R10: Each pop moves every level up one place and leaves the bottom level unchanged. Once the stack is empty, a further pop therefore returns the bottom level again.
- R11: When several strobes are high together, exactly one operation is taken. The order from highest to lowest is: interrupt return, constant return, interrupt entry, call, jump, table jump, increment.
- R12: With no strobe high, `fetch_addr` holds its value. At the update edge, `carry_out`, `tbr_out` and `acc_out` take `carry_in`, `tbr_in` and `acc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_inc | input | 1 | Sequential increment strobe |
| op_jump | input | 1 | Absolute jump strobe |
| op_call | input | 1 | Subroutine call strobe |
| op_irq | input | 1 | Interrupt entry strobe |
| op_reti | input | 1 | Return restoring carry |
| op_retc | input | 1 | Return loading a constant byte |
| op_tjmp | input | 1 | Table jump strobe |
| jump_addr | input | 12 | Target for jump and call |
| carry_in | input | 1 | Live carry flag from the ALU |
| acc_in | input | 4 | Live accumulator nibble |
| tbr_in | input | 4 | Live table-branch nibble |
| rom_data | input | 16 | Word read from program ROM |
| fetch_addr | output | 12 | Program counter / fetch address |
| carry_out | output | 1 | Carry value after this cycle |
| tbr_out | output | 4 | Table-branch nibble after this cycle |
| acc_out | output | 4 | Accumulator nibble after this cycle |
| cyc_strobe | output | 1 | High on the clock whose rising edge ends an instruction cycle |

## Verification
A corrupted stack level stays hidden until it is popped. It then appears at the next update edge as a wrong `fetch_addr`, and as a wrong `carry_out` if the pop was an interrupt return. This can happen many instruction cycles after the damage. For that reason the bench runs deep call chains, overflows the stack and pops it past empty, so that every level reaches the ports. A phase counter that drifts appears within four clocks, as an output that changes on an edge where `cyc_strobe` was low. A wrong priority shows at the very next update edge.

// File: rtl/pcs_pkg.sv
// Shared types for the program counter sequencer.
// Assumes at most one operation is selected per instruction cycle.
package pcs_pkg;
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_INC,
        OP_TJMP,
        OP_JMP,
        OP_CALL,
        OP_INTR,
        OP_RETC,
        OP_RETI
    } pc_op_e;
endpackage

// File: rtl/pcs_phase.sv
// Instruction-cycle phase divider: counts oscillator clocks and raises
// a strobe on the last clock of each cycle. Assumes DIV >= 2.
module pcs_phase #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Advance the phase and wrap after the last clock of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign strobe = (cnt == LAST);

    // R2: the strobe never lasts two consecutive clocks.
    assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/pcs_opsel.sv
// Priority selector: turns the raw operation strobes into one encoded
// operation. Assumes the caller qualifies the result with the cycle strobe.
module pcs_opsel
    import pcs_pkg::*;
(
    input  logic   op_inc,
    input  logic   op_jump,
    input  logic   op_call,
    input  logic   op_irq,
    input  logic   op_reti,
    input  logic   op_retc,
    input  logic   op_tjmp,
    output pc_op_e op_sel
);
    // Fixed order: returns first, then entries, then plain flow changes.
    always_comb begin
        if (op_reti)       op_sel = OP_RETI;
        else if (op_retc)  op_sel = OP_RETC;
        else if (op_irq)   op_sel = OP_INTR;
        else if (op_call)  op_sel = OP_CALL;
        else if (op_jump)  op_sel = OP_JMP;
        else if (op_tjmp)  op_sel = OP_TJMP;
        else if (op_inc)   op_sel = OP_INC;
        else               op_sel = OP_HOLD;
    end
endmodule

// File: rtl/pcs_next.sv
// Next-state logic: computes the next program counter, the stack request
// and the next carry / table-branch / accumulator values from the selected
// operation. Purely combinational; assumes PC_W > 8.
module pcs_next
    import pcs_pkg::*;
#(
    parameter int              PC_W    = 12,
    parameter logic [PC_W-1:0] INT_VEC = 12'h008
) (
    input  pc_op_e          op_sel,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] jump_addr,
    input  logic            carry_in,
    input  logic [3:0]      tbr_in,
    input  logic [3:0]      acc_in,
    input  logic [7:0]      rom_low,
    input  logic [PC_W:0]   stack_top,
    output logic [PC_W-1:0] pc_nxt,
    output logic            push_req,
    output logic            pop_req,
    output logic [PC_W:0]   push_data,
    output logic            carry_nxt,
    output logic [3:0]      tbr_nxt,
    output logic [3:0]      acc_nxt
);
    localparam int CNT_W = PC_W - 1;

    logic [PC_W-1:0] pc_inc;

    // Increment within the counting field, leaving the page bit alone.
    always_comb begin
        pc_inc = {pc[PC_W-1], pc[CNT_W-1:0] + CNT_W'(1)};
    end

    // Select the next values for the chosen operation.
    always_comb begin
        pc_nxt    = pc;
        push_req  = 1'b0;
        pop_req   = 1'b0;
        push_data = '0;
        carry_nxt = carry_in;
        tbr_nxt   = tbr_in;
        acc_nxt   = acc_in;
        unique case (op_sel)
            OP_HOLD: pc_nxt = pc;
            OP_INC:  pc_nxt = pc_inc;
            OP_TJMP: pc_nxt = {pc[PC_W-1:8], tbr_in, acc_in};
            OP_JMP:  pc_nxt = jump_addr;
            OP_CALL: begin
                pc_nxt    = {pc[PC_W-1], jump_addr[CNT_W-1:0]};
                push_req  = 1'b1;
                push_data = {carry_in, pc_inc};
            end
            OP_INTR: begin
                pc_nxt    = INT_VEC;
                push_req  = 1'b1;
                push_data = {carry_in, pc};
            end
            OP_RETC: begin
                pc_nxt  = stack_top[PC_W-1:0];
                pop_req = 1'b1;
                tbr_nxt = rom_low[7:4];
                acc_nxt = rom_low[3:0];
            end
            OP_RETI: begin
                pc_nxt    = stack_top[PC_W-1:0];
                pop_req   = 1'b1;
                carry_nxt = stack_top[PC_W];
            end
            default: pc_nxt = pc;
        endcase
    end

    // R11: push and pop are never requested together.
    assert_push_pop_excl_R11: assert final (!(push_req && pop_req));
endmodule

// File: rtl/pcs_stack.sv
// Return stack built as a shift register: level 0 is the top. A push
// shifts every level down and drops the bottom; a pop shifts every level
// up and keeps the bottom. A depth counter saturates at 0 and at DEPTH.
// Assumes push and pop are never high together and DEPTH >= 2.
module pcs_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);
    localparam int DW = $clog2(DEPTH + 1);
    localparam logic [DW-1:0] FULL = DW'(DEPTH);

    logic [W-1:0]  lvl [DEPTH];
    logic [DW-1:0] depth;

    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        if (i == 0) begin : g_top
            // Top level: takes new data on push, the level below on pop.
            always_ff @(posedge clk) begin
                if (!rst_n)     lvl[i] <= '0;
                else if (push)  lvl[i] <= din;
                else if (pop)   lvl[i] <= lvl[i+1];
            end
        end else if (i == DEPTH - 1) begin : g_bot
            // Bottom level: takes the level above on push, holds on pop.
            always_ff @(posedge clk) begin
                if (!rst_n)     lvl[i] <= '0;
                else if (push)  lvl[i] <= lvl[i-1];
            end
        end else begin : g_mid
            // Middle level: shifts down on push, up on pop.
            always_ff @(posedge clk) begin
                if (!rst_n)     lvl[i] <= '0;
                else if (push)  lvl[i] <= lvl[i-1];
                else if (pop)   lvl[i] <= lvl[i+1];
            end
        end
    end

    // Track how many levels hold live entries, saturating both ways.
    always_ff @(posedge clk) begin
        if (!rst_n)                           depth <= '0;
        else if (push && depth != FULL)       depth <= depth + 1'b1;
        else if (pop && depth != '0)          depth <= depth - 1'b1;
    end

    assign top = lvl[0];

    // R9: the live count never exceeds the number of levels.
    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= FULL);
    // R9: a push on a full stack keeps it full and moves the next-oldest down.
    assert_overflow_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && depth == FULL) |=> (depth == FULL && lvl[DEPTH-1] == $past(lvl[DEPTH-2])));
    // R10: a pop keeps the bottom level in place.
    assert_bottom_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> $stable(lvl[DEPTH-1]));
endmodule

// File: rtl/pcs_top.sv
// Program counter sequencer top: phase divider, operation selector,
// next-state logic and return stack around the architectural registers.
// Assumes the strobes are held by decode through the cycle's last clock.
module pcs_top #(
    parameter int                PC_W    = 12,
    parameter int                DEPTH   = 8,
    parameter int                DIV     = 4,
    parameter logic [PC_W-1:0]   INT_VEC = 12'h008
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_inc,
    input  logic            op_jump,
    input  logic            op_call,
    input  logic            op_irq,
    input  logic            op_reti,
    input  logic            op_retc,
    input  logic            op_tjmp,
    input  logic [PC_W-1:0] jump_addr,
    input  logic            carry_in,
    input  logic [3:0]      acc_in,
    input  logic [3:0]      tbr_in,
    input  logic [15:0]     rom_data,
    output logic [PC_W-1:0] fetch_addr,
    output logic            carry_out,
    output logic [3:0]      tbr_out,
    output logic [3:0]      acc_out,
    output logic            cyc_strobe
);
    import pcs_pkg::*;

    localparam int CNT_W = PC_W - 1;
    localparam int SW    = PC_W + 1;

    pc_op_e          op_sel;
    logic [PC_W-1:0] pc_q, pc_nxt;
    logic            carry_q, carry_nxt;
    logic [3:0]      tbr_q, tbr_nxt, acc_q, acc_nxt;
    logic            push_req, pop_req;
    logic [SW-1:0]   push_data, stack_top;
    logic            unused_rom_hi;

    assign unused_rom_hi = ^rom_data[15:8];

    pcs_phase #(.DIV(DIV)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cyc_strobe)
    );

    pcs_opsel u_opsel (
        .op_inc  (op_inc),
        .op_jump (op_jump),
        .op_call (op_call),
        .op_irq  (op_irq),
        .op_reti (op_reti),
        .op_retc (op_retc),
        .op_tjmp (op_tjmp),
        .op_sel  (op_sel)
    );

    pcs_next #(.PC_W(PC_W), .INT_VEC(INT_VEC)) u_next (
        .op_sel    (op_sel),
        .pc        (pc_q),
        .jump_addr (jump_addr),
        .carry_in  (carry_in),
        .tbr_in    (tbr_in),
        .acc_in    (acc_in),
        .rom_low   (rom_data[7:0]),
        .stack_top (stack_top),
        .pc_nxt    (pc_nxt),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .push_data (push_data),
        .carry_nxt (carry_nxt),
        .tbr_nxt   (tbr_nxt),
        .acc_nxt   (acc_nxt)
    );

    pcs_stack #(.DEPTH(DEPTH), .W(SW)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_req && cyc_strobe),
        .pop   (pop_req && cyc_strobe),
        .din   (push_data),
        .top   (stack_top)
    );

    // Commit the next architectural state once per instruction cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            carry_q <= 1'b0;
            tbr_q   <= '0;
            acc_q   <= '0;
        end else if (cyc_strobe) begin
            pc_q    <= pc_nxt;
            carry_q <= carry_nxt;
            tbr_q   <= tbr_nxt;
            acc_q   <= acc_nxt;
        end
    end

    assign fetch_addr = pc_q;
    assign carry_out  = carry_q;
    assign tbr_out    = tbr_q;
    assign acc_out    = acc_q;

    // R2: outside the update edge nothing visible moves.
    assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_strobe |=> ($stable(fetch_addr) && $stable(carry_out)
                         && $stable(tbr_out) && $stable(acc_out)));
    // R3: a lone increment bumps the count field and keeps the page bit.
    assert_inc_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && op_inc && !(op_jump || op_call || op_irq || op_reti || op_retc || op_tjmp))
        |=> (fetch_addr[PC_W-1] == $past(fetch_addr[PC_W-1])
             && fetch_addr[CNT_W-1:0] == CNT_W'($past(fetch_addr[CNT_W-1:0]) + 1'b1)));
    // R7: a constant return leaves the live carry and loads the ROM byte.
    assert_retc_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && op_retc && !op_reti)
        |=> (carry_out == $past(carry_in) && {tbr_out, acc_out} == $past(rom_data[7:0])));
    // R8: a lone table jump splices the nibbles under the kept high bits.
    assert_tjmp_splice_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_strobe && op_tjmp && !(op_jump || op_call || op_irq || op_reti || op_retc))
        |=> fetch_addr == {$past(fetch_addr[PC_W-1:8]), $past(tbr_in), $past(acc_in)});
endmodule

// File: tb/sim_pcs_top.sv
// Bench for pcs_top: behavioural reference model compared every clock,
// plus named checks at the interesting points of each scenario.
module sim_pcs_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] M_INC  = 7'b0000001;
    localparam logic [6:0] M_TJ   = 7'b0000010;
    localparam logic [6:0] M_JMP  = 7'b0000100;
    localparam logic [6:0] M_CALL = 7'b0001000;
    localparam logic [6:0] M_IRQ  = 7'b0010000;
    localparam logic [6:0] M_RETC = 7'b0100000;
    localparam logic [6:0] M_RETI = 7'b1000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_inc = 0, op_jump = 0, op_call = 0, op_irq = 0;
    logic op_reti = 0, op_retc = 0, op_tjmp = 0;
    logic [11:0] jump_addr = '0;
    logic carry_in = 1'b0;
    logic [3:0] acc_in = '0, tbr_in = '0;
    logic [15:0] rom_data = '0;
    logic [11:0] fetch_addr;
    logic carry_out, cyc_strobe;
    logic [3:0] tbr_out, acc_out;

    int n_chk = 0, n_fail = 0;
    bit cmp_en = 0, done = 0;
    string cur_req = "R1";

    // Reference state.
    logic [11:0] m_pc;
    logic m_c;
    logic [3:0] m_tbr, m_acc;
    int m_ph;
    logic [12:0] stk[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcs_top u0 (
        .clk(clk), .rst_n(rst_n), .op_inc(op_inc), .op_jump(op_jump),
        .op_call(op_call), .op_irq(op_irq), .op_reti(op_reti),
        .op_retc(op_retc), .op_tjmp(op_tjmp), .jump_addr(jump_addr),
        .carry_in(carry_in), .acc_in(acc_in), .tbr_in(tbr_in),
        .rom_data(rom_data), .fetch_addr(fetch_addr), .carry_out(carry_out),
        .tbr_out(tbr_out), .acc_out(acc_out), .cyc_strobe(cyc_strobe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] inc11(input logic [11:0] a);
        return {a[11], 11'(a[10:0] + 11'd1)};
    endfunction

    function automatic logic [12:0] mpop();
        logic [12:0] v;
        v = stk.pop_front();
        stk.push_back(stk[stk.size()-1]);
        return v;
    endfunction

    // Reference model: phase, priority and stack written behaviourally.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = '0; m_c = 0; m_tbr = '0; m_acc = '0; m_ph = 0;
            stk = {};
            for (int i = 0; i < 8; i++) stk.push_back(13'd0);
        end else begin
            if (m_ph == 3) begin
                logic [12:0] e;
                m_c = carry_in; m_tbr = tbr_in; m_acc = acc_in;
                if (op_reti) begin
                    e = mpop(); m_pc = e[11:0]; m_c = e[12];
                end else if (op_retc) begin
                    e = mpop(); m_pc = e[11:0];
                    m_tbr = rom_data[7:4]; m_acc = rom_data[3:0];
                end else if (op_irq) begin
                    stk.push_front({carry_in, m_pc}); void'(stk.pop_back());
                    m_pc = 12'h008;
                end else if (op_call) begin
                    stk.push_front({carry_in, inc11(m_pc)}); void'(stk.pop_back());
                    m_pc = {m_pc[11], jump_addr[10:0]};
                end else if (op_jump) m_pc = jump_addr;
                else if (op_tjmp) m_pc = {m_pc[11:8], tbr_in, acc_in};
                else if (op_inc)  m_pc = inc11(m_pc);
            end
            m_ph = (m_ph + 1) % 4;
        end
    end

    // Compare every output against the model away from the clock edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk({cur_req, " fetch_addr"}, int'(fetch_addr), int'(m_pc));
            chk({cur_req, " carry_out"}, int'(carry_out), int'(m_c));
            chk({cur_req, " tbr_out"}, int'(tbr_out), int'(m_tbr));
            chk({cur_req, " acc_out"}, int'(acc_out), int'(m_acc));
            chk("R2 cyc_strobe", int'(cyc_strobe), int'(m_ph == 3));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input logic [6:0] m, input logic [11:0] a);
        {op_reti, op_retc, op_irq, op_call, op_jump, op_tjmp, op_inc} = m;
        jump_addr = a;
        step(4);
        {op_reti, op_retc, op_irq, op_call, op_jump, op_tjmp, op_inc} = '0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        chk("R1 fetch_addr", int'(fetch_addr), 0);
        chk("R1 carry_out", int'(carry_out), 0);
        chk("R1 tbr_out", int'({tbr_out, acc_out}), 0);
        chk("R1 cyc_strobe", int'(cyc_strobe), 0);
        cmp_en = 1;

        cur_req = "R12";
        carry_in = 1; tbr_in = 4'h5; acc_in = 4'hA;
        issue(7'd0, 12'h000);
        chk("R12 hold", int'({carry_out, tbr_out, acc_out, fetch_addr}), 'h15A000);

        cur_req = "R3";
        issue(M_JMP, 12'h7FE);
        issue(M_INC, 12'h0);
        chk("R3 inc", int'(fetch_addr), 'h7FF);
        issue(M_INC, 12'h0);
        chk("R3 wrap low page", int'(fetch_addr), 'h000);
        issue(M_JMP, 12'hFFF);
        issue(M_INC, 12'h0);
        chk("R3 wrap keeps page", int'(fetch_addr), 'h800);

        cur_req = "R2";
        while (cyc_strobe !== 1'b1) step(1);
        step(1);
        op_jump = 1; jump_addr = 12'h555;
        step(1);
        op_jump = 0;
        step(4);
        chk("R2 off-phase jump ignored", int'(fetch_addr), 'h800);

        cur_req = "R4";
        issue(M_JMP, 12'h8F0);
        carry_in = 1;
        issue(M_CALL, 12'h123);
        chk("R4 call keeps page", int'(fetch_addr), 'h923);

        cur_req = "R5";
        carry_in = 0;
        issue(M_IRQ, 12'h0);
        chk("R5 vector", int'(fetch_addr), 'h008);

        cur_req = "R6";
        carry_in = 1;
        issue(M_RETI, 12'h0);
        chk("R6 reti pc", int'(fetch_addr), 'h923);
        chk("R6 reti carry", int'(carry_out), 0);
        carry_in = 0;
        issue(M_RETI, 12'h0);
        chk("R6 reti pc 2", int'(fetch_addr), 'h8F1);
        chk("R6 reti carry 2", int'(carry_out), 1);

        cur_req = "R7";
        issue(M_CALL, 12'h040);
        carry_in = 1; rom_data = 16'h12C7;
        issue(M_RETC, 12'h0);
        chk("R7 retc pc", int'(fetch_addr), 'h8F2);
        chk("R7 retc carry", int'(carry_out), 1);
        chk("R7 retc nibbles", int'({tbr_out, acc_out}), 'hC7);

        cur_req = "R8";
        tbr_in = 4'h3; acc_in = 4'h9;
        issue(M_TJ, 12'h0);
        chk("R8 tjmp", int'(fetch_addr), 'h839);

        cur_req = "R11";
        issue(M_CALL | M_JMP | M_INC | M_TJ, 12'h0AB);
        chk("R11 call over jump", int'(fetch_addr), 'h8AB);
        issue(M_IRQ | M_CALL, 12'h100);
        chk("R11 irq over call", int'(fetch_addr), 'h008);
        issue(M_RETC | M_RETI | M_IRQ, 12'h0);
        chk("R11 reti first", int'(fetch_addr), 'h8AB);
        issue(M_RETC | M_CALL, 12'h0);
        chk("R11 retc over call", int'(fetch_addr), 'h83A);

        cur_req = "R9";
        issue(M_JMP, 12'h010);
        for (int k = 0; k <= 8; k++) begin
            carry_in = k[0];
            issue(M_CALL, 12'(12'h100 + k));
        end
        carry_in = 0;
        for (int k = 8; k >= 1; k--) begin
            issue(M_RETI, 12'h0);
            chk("R9 overflow pop pc", int'(fetch_addr), 'h100 + k);
            chk("R9 overflow pop carry", int'(carry_out), k % 2);
        end

        cur_req = "R10";
        issue(M_RETI, 12'h0);
        chk("R10 empty pop pc", int'(fetch_addr), 'h101);
        chk("R10 empty pop carry", int'(carry_out), 1);
        issue(M_RETC, 12'h0);
        chk("R10 empty pop again", int'(fetch_addr), 'h101);

        done = 1;
        cmp_en = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule